// File: doc/BRIEF.md
# DMA Channel Control and Status Register

This unit holds the status word of one channel of a descriptor-driven DMA engine. The word has seven flags: run, pause, flush, wake, dead, active and branch-taken. It also has an 8-bit device status field. Software reads the word through a simple 32-bit register port. Software never writes the status word directly. It writes a control word instead, in which the upper 16 bits choose the status bits to change and the lower 16 bits give their new values. Bits outside the chosen set keep their values, so several agents can share the word without read-modify-write races.

The command engine sees every flag on dedicated outputs. It reports its own events on single-cycle inputs: it starts or finishes a descriptor (active), hits a fatal bus error (dead), takes or clears a branch (branch-taken), and finishes draining stream data (flush). The unit implements two software polling handshakes. To stop, software clears run and flush together, then waits until active and flush both read 0. To reset, software clears the six upper control flags in one write, then waits until run reads 0.

Status word layout, least significant bit first: bits 7:0 are device status, bit 8 is branch-taken, bit 9 is reserved, bit 10 is active, bit 11 is dead, bit 12 is wake, bit 13 is flush, bit 14 is pause and bit 15 is run. Register address 0 is the control word, which is write-only and reads as zero. Register address 1 is the status word, which is read-only. Words are little-endian, so bit 0 travels in byte lane 0.

Top module: `dma_chan_csr`

## Requirements
- R1: After reset every status bit is 0, and a read of address 1 returns 0.
- R2: A write to address 0 sets status bit i (for i in 15:0) to wdata[i] when wdata[16+i] is 1, and leaves it unchanged otherwise. The device status field bits 7:0 follow this rule exactly.
- R3: A write to address 1 changes nothing. A read of address 0 returns 0. A read of address 1 returns 0 in bits 31:16 and in the reserved bit 9.
- R4: When a control write sets wake (bit 12), wake reads 1 for exactly one cycle and then returns to 0 unless it is written again.
- R5: The engine can set active (bit 10) only when run (bit 15) is 1 and dead (bit 11) is 0. The engine's clear event drops active. A software write can clear active but cannot set it.
- R6: The engine's error event sets dead, and this wins over a software clear of dead in the same cycle. While dead is 1, active is forced to 0. Only a software write clears dead.
- R7: The engine's events set and clear branch-taken (bit 8). A software write that selects bit 8 wins over an engine event in the same cycle.
- R8: A control write that clears run while active is 1, and that does not select active, leaves flush (bit 13) at 1 until the engine reports the drain complete. Active stays 1 until the engine's clear event.
- R9: A software write of 1 sets flush, and flush holds until the engine's flush-done event clears it.
- R10: A single write with upper half 0xFC00 and lower half 0 clears bits 15:10 in the next cycle. It does not start a drain, and it leaves bit 8 and bits 7:0 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects the control word, 1 selects the status word |
| reg_wdata | input | 32 | Write data; bits 31:16 are the change mask, bits 15:0 the new values |
| reg_rdata | output | 32 | Read data for the selected register |
| eng_active_set | input | 1 | Engine has started a descriptor |
| eng_active_clr | input | 1 | Engine has finished or abandoned a descriptor |
| eng_dead_set | input | 1 | Engine hit a fatal bus error |
| eng_bt_set | input | 1 | Engine took a branch |
| eng_bt_clr | input | 1 | Engine clears the branch-taken flag |
| eng_flush_done | input | 1 | Pending stream data has been written out |
| st_run | output | 1 | Run flag |
| st_pause | output | 1 | Pause flag |
| st_flush | output | 1 | Flush flag |
| st_wake | output | 1 | Wake pulse; the engine refetches the current command |
| st_dead | output | 1 | Dead flag |
| st_active | output | 1 | Active flag |
| st_bt | output | 1 | Branch-taken flag |
| st_devstat | output | 8 | Device status field |

## Verification
The assertions check several invariants on every cycle:
- active never reads 1 while dead is 1;
- active and dead rise only after the matching engine event or control write;
- flush rises only after a control write;
- run holds whenever no write selects it;
- wake falls one cycle after it rises unless a write renews it;
- the reserved read bits stay at 0.

Only the bench's scenarios can show the rest. These are the masked merge across all device status values and several masks, the order in which same-cycle software and engine updates win, and the full stop and reset polling sequences.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = WORD_W / 2;
  localparam int DEV_W  = 8;

  localparam logic ADDR_CTL  = 1'b0;
  localparam logic ADDR_STAT = 1'b1;

  // Packed so that run lands on bit 15 and dev on bits 7:0
  typedef struct packed {
    logic             run;
    logic             pause;
    logic             flush;
    logic             wake;
    logic             dead;
    logic             active;
    logic             rsvd;
    logic             bt;
    logic [DEV_W-1:0] dev;
  } stat_t;

  typedef struct packed {
    logic act_set;
    logic act_clr;
    logic dead_set;
    logic bt_set;
    logic bt_clr;
    logic flush_done;
  } eng_ev_t;
endpackage

// File: rtl/dma_csr_rst_sync.sv
module dma_csr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/dma_csr_wr_decode.sv
module dma_csr_wr_decode
  import dma_csr_pkg::*;
(
  input  logic              reg_we,
  input  logic              reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic              ctl_we,
  output stat_t             sel,
  output stat_t             val
);
  // Only the control address can change state; status writes are dropped
  assign ctl_we = reg_we && (reg_addr == ADDR_CTL);

  always_comb begin
    sel = '0;
    val = '0;
    if (ctl_we) begin
      sel = stat_t'(reg_wdata[WORD_W-1:HALF_W]);
      val = stat_t'(reg_wdata[HALF_W-1:0]);
    end
  end
endmodule

// File: rtl/dma_csr_next.sv
module dma_csr_next
  import dma_csr_pkg::*;
(
  input  stat_t   cur,
  input  stat_t   sel,
  input  stat_t   val,
  input  eng_ev_t ev,
  output stat_t   nxt
);
  logic [DEV_W-1:0] dev_nx;
  logic run_nx, dead_nx, drain;

  // Plain masked merge on the device status field
  for (genvar i = 0; i < DEV_W; i++) begin : g_dev
    assign dev_nx[i] = sel.dev[i] ? val.dev[i] : cur.dev[i];
  end

  always_comb begin
    run_nx  = sel.run  ? val.run  : cur.run;
    dead_nx = ev.dead_set | (sel.dead ? val.dead : cur.dead);
    // Stop while busy: keep flush up until the engine drains
    drain   = sel.run & ~val.run & cur.run & cur.active & ~sel.active;

    nxt        = '0;
    nxt.dev    = dev_nx;
    nxt.run    = run_nx;
    nxt.pause  = sel.pause ? val.pause : cur.pause;
    nxt.dead   = dead_nx;
    nxt.wake   = sel.wake & val.wake;
    nxt.flush  = drain | (sel.flush ? val.flush : (cur.flush & ~ev.flush_done));
    nxt.active = ~dead_nx & ~(sel.active & ~val.active)
               & ((cur.active & ~ev.act_clr) | (ev.act_set & run_nx));
    nxt.bt     = sel.bt ? val.bt : (ev.bt_set | (cur.bt & ~ev.bt_clr));
    nxt.rsvd   = 1'b0;
  end
endmodule

// File: rtl/dma_chan_csr.sv
module dma_chan_csr
  import dma_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              eng_active_set,
  input  logic              eng_active_clr,
  input  logic              eng_dead_set,
  input  logic              eng_bt_set,
  input  logic              eng_bt_clr,
  input  logic              eng_flush_done,
  output logic              st_run,
  output logic              st_pause,
  output logic              st_flush,
  output logic              st_wake,
  output logic              st_dead,
  output logic              st_active,
  output logic              st_bt,
  output logic [DEV_W-1:0]  st_devstat
);
  logic    rst_sync_n;
  logic    ctl_we;
  logic    upd_en;
  stat_t   sel, val, stat_q, stat_nx;
  eng_ev_t ev;

  dma_csr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  dma_csr_wr_decode u_dec (
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .ctl_we(ctl_we), .sel(sel), .val(val)
  );

  always_comb begin
    ev.act_set    = eng_active_set;
    ev.act_clr    = eng_active_clr;
    ev.dead_set   = eng_dead_set;
    ev.bt_set     = eng_bt_set;
    ev.bt_clr     = eng_bt_clr;
    ev.flush_done = eng_flush_done;
  end

  dma_csr_next u_nxt (
    .cur(stat_q), .sel(sel), .val(val), .ev(ev), .nxt(stat_nx)
  );

  // The word moves only on a write, an engine event, or the wake fall
  assign upd_en = ctl_we | (|ev) | stat_q.wake;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  stat_q <= '0;
    else if (upd_en)  stat_q <= stat_nx;
  end

  assign reg_rdata  = (reg_addr == ADDR_STAT) ? {{HALF_W{1'b0}}, stat_q} : '0;
  assign st_run     = stat_q.run;
  assign st_pause   = stat_q.pause;
  assign st_flush   = stat_q.flush;
  assign st_wake    = stat_q.wake;
  assign st_dead    = stat_q.dead;
  assign st_active  = stat_q.active;
  assign st_bt      = stat_q.bt;
  assign st_devstat = stat_q.dev;
endmodule

// File: rtl/dma_chan_csr_chk.sv
module dma_chan_csr_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_we,
  input logic        reg_addr,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata,
  input logic        eng_active_set,
  input logic        eng_dead_set,
  input logic        st_run,
  input logic        st_flush,
  input logic        st_wake,
  input logic        st_dead,
  input logic        st_active
);
  logic ctl_we;
  assign ctl_we = reg_we && !reg_addr;

  // R2
  run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl_we && reg_wdata[31]) |=> $stable(st_run));

  // R3
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[31:16] == 16'h0) && !reg_rdata[9]);

  // R4
  wake_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_wake && !(ctl_we && reg_wdata[28] && reg_wdata[12]) |=> !st_wake);

  // R5
  active_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_active) |-> st_run && $past(eng_active_set));

  // R6
  dead_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_dead |-> !st_active);

  // R6
  dead_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_dead) |-> $past(eng_dead_set) || $past(ctl_we));

  // R9
  flush_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_flush) |-> $past(ctl_we));
endmodule

bind dma_chan_csr dma_chan_csr_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .eng_active_set(eng_active_set), .eng_dead_set(eng_dead_set),
  .st_run(st_run), .st_flush(st_flush), .st_wake(st_wake),
  .st_dead(st_dead), .st_active(st_active)
);

// File: tb/dma_chan_csr_bench.sv
module dma_chan_csr_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic        reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [5:0]  ev;   // {act_set, act_clr, dead_set, bt_set, bt_clr, flush_done}
  logic st_run, st_pause, st_flush, st_wake, st_dead, st_active, st_bt;
  logic [7:0]  st_devstat;
  int nchk = 0;
  int nfail = 0;

  localparam logic [5:0] E_ASET = 6'b100000, E_ACLR = 6'b010000,
                         E_DEAD = 6'b001000, E_BSET = 6'b000100,
                         E_BCLR = 6'b000010, E_FDON = 6'b000001;

  always #5 clk = ~clk;

  dma_chan_csr u_dma_chan_csr (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .eng_active_set(ev[5]), .eng_active_clr(ev[4]), .eng_dead_set(ev[3]),
    .eng_bt_set(ev[2]), .eng_bt_clr(ev[1]), .eng_flush_done(ev[0]),
    .st_run(st_run), .st_pause(st_pause), .st_flush(st_flush),
    .st_wake(st_wake), .st_dead(st_dead), .st_active(st_active),
    .st_bt(st_bt), .st_devstat(st_devstat)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // One cycle of stimulus, starting just after a falling edge; leaves the
  // port idle on the status address a little after the next falling edge
  task automatic cyc(input logic we, input logic addr, input logic [31:0] d,
                     input logic [5:0] e);
    reg_we = we; reg_addr = addr; reg_wdata = d; ev = e;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 1'b1; reg_wdata = '0; ev = '0;
    #1;
  endtask

  task automatic ctl(input logic [15:0] m, input logic [15:0] v);
    cyc(1'b1, 1'b0, {m, v}, 6'b0);
  endtask

  task automatic evt(input logic [5:0] e);
    cyc(1'b0, 1'b1, 32'h0, e);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [7:0] dev_exp;
    logic [7:0] masks [4];
    masks = '{8'hFF, 8'h0F, 8'hA5, 8'h00};
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = 1'b1; reg_wdata = '0; ev = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk("R1 status after reset", reg_rdata, 32'h0);
    reg_addr = 1'b0; #1;
    chk("R3 control reads zero", reg_rdata, 32'h0);
    reg_addr = 1'b1; #1;

    // R2: device status masked merge sweep
    dev_exp = 8'h00;
    for (int mi = 0; mi < 4; mi++) begin
      for (int v = 0; v < 256; v++) begin
        ctl({8'h00, masks[mi]}, {8'h00, 8'(v)});
        dev_exp = (dev_exp & ~masks[mi]) | (8'(v) & masks[mi]);
        chk("R2 devstat merge", reg_rdata, {24'h0, dev_exp});
      end
    end

    // R3: write to status address ignored; reserved bit never set
    cyc(1'b1, 1'b1, 32'hFFFF_FFFF, 6'b0);
    chk("R3 status write ignored", reg_rdata, {24'h0, dev_exp});
    ctl(16'h0200, 16'h0200);
    chk("R3 reserved bit 9", reg_rdata, {24'h0, dev_exp});

    // R4: wake pulse
    ctl(16'h1000, 16'h1000);
    chk("R4 wake set", {31'h0, st_wake}, 32'h1);
    @(negedge clk); #1;
    chk("R4 wake self-clear", {31'h0, st_wake}, 32'h0);

    // R5: active gating
    evt(E_ASET);
    chk("R5 no active without run", {31'h0, st_active}, 32'h0);
    ctl(16'h8000, 16'h8000);
    evt(E_ASET);
    chk("R5 engine sets active", {31'h0, st_active}, 32'h1);
    evt(E_ACLR);
    chk("R5 engine clears active", {31'h0, st_active}, 32'h0);
    ctl(16'h0400, 16'h0400);
    chk("R5 software cannot set active", {31'h0, st_active}, 32'h0);
    evt(E_ASET);
    ctl(16'h0400, 16'h0000);
    chk("R5 software clears active", {31'h0, st_active}, 32'h0);

    // R6: dead
    evt(E_ASET);
    evt(E_DEAD);
    chk("R6 dead set", {30'h0, st_dead, st_active}, 32'h2);
    evt(E_ASET);
    chk("R6 dead blocks active", {31'h0, st_active}, 32'h0);
    cyc(1'b1, 1'b0, {16'h0800, 16'h0000}, E_DEAD);
    chk("R6 engine dead wins", {31'h0, st_dead}, 32'h1);
    ctl(16'h0800, 16'h0000);
    chk("R6 software clears dead", {31'h0, st_dead}, 32'h0);
    evt(E_ASET);
    chk("R6 active allowed again", {31'h0, st_active}, 32'h1);
    evt(E_ACLR);

    // R7: branch taken
    evt(E_BSET);
    chk("R7 bt set", {31'h0, st_bt}, 32'h1);
    evt(E_BCLR);
    chk("R7 bt clear", {31'h0, st_bt}, 32'h0);
    cyc(1'b1, 1'b0, {16'h0100, 16'h0000}, E_BSET);
    chk("R7 software bt wins", {31'h0, st_bt}, 32'h0);

    // R8: stop handshake (run is 1 here)
    evt(E_ASET);
    ctl(16'hA000, 16'h0000);
    chk("R8 stop run/flush/active", {29'h0, st_run, st_flush, st_active}, 32'h3);
    evt(E_FDON);
    chk("R8 drain done", {29'h0, st_run, st_flush, st_active}, 32'h1);
    evt(E_ACLR);
    chk("R8 idle", {29'h0, st_run, st_flush, st_active}, 32'h0);

    // R9: software flush
    ctl(16'h2000, 16'h2000);
    chk("R9 flush set", {31'h0, st_flush}, 32'h1);
    repeat (3) @(negedge clk);
    #1;
    chk("R9 flush holds", {31'h0, st_flush}, 32'h1);
    evt(E_FDON);
    chk("R9 flush cleared", {31'h0, st_flush}, 32'h0);

    // R10: reset handshake with everything busy
    ctl(16'hE000, 16'hE000);
    evt(E_ASET | E_BSET);
    chk("R10 busy before reset", reg_rdata[15:8], 8'hE5);
    ctl(16'hFC00, 16'h0000);
    chk("R10 reset write", reg_rdata, {16'h0, 8'h01, dev_exp});

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule